// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Syndrome Encoding

This block decides how a 32-bit effective address becomes a real address for one access and, if the access cannot complete, which exception to raise and what to record. The access may be an instruction fetch, a load or a store. The block applies the translation stages in a fixed order: real mode first, then a block-translation hit, then the segment register. The segment register then selects one of three paths: a direct-store segment (which includes a memory-forced I/O bypass), a segment-level no-execute check, or a page-table lookup with protection-key checking.

The block does not search the hashed page table and does not match block-translation registers. It receives those results on its inputs in the same cycle as the request, together with the segment register file. A request is a single-cycle strobe. One cycle later the result is registered: the real address, the permitted access set, the exception kind, the instruction error code, the data syndrome word and the fault address. The result comes with a one-cycle done pulse and stays stable until the next request.

Top module: `xlate_seq`

## Requirements
- R1: When `req_real` is 1, the result is real address = effective address, permission 3'b111, and exception kind 0 (none), whatever the other inputs are.
- R2: A block-translation hit (`bt_hit`=1) takes priority over every segment path.
  - If the access has its needed permission in `bt_perm`, the result carries `bt_raddr` and `bt_perm`.
  - Otherwise a fetch raises instruction fault (kind 1) with code 0x08000000.
  - Otherwise a load or store raises data fault (kind 2) with syndrome 0x08000000, or 0x0A000000 for stores.
  - Needed permission: fetch needs X, load needs R, store needs W. Permission bit 0 is R, bit 1 is W, bit 2 is X.
  - Access kinds: 0 is fetch, 1 is load, 2 is store.
- R3: The segment register used is slot `req_ea[31:28]` of `seg_file`. Slot n occupies bits 32n+31 down to 32n.
- R4: A segment with direct-store bit 31 set and bus unit field bits 28:20 equal to 0x07F yields real address {seg[3:0], ea[27:0]} with permission 3'b111 and no fault.
- R5: Any other direct-store segment behaves as follows.
  - A fetch raises an instruction fault with code 0x10000000.
  - An integer data access (class 0) is granted read+write (3'b011) when the selected key is 1, and read only (3'b001) when the key is 0. The real address equals the effective address.
  - A missing permission raises a data fault with syndrome 0x08000000 (0x0A000000 for stores).
- R6: In a direct-store segment other than the bypass, the remaining data classes behave as follows.
  - Reservation class 2 raises a data fault with syndrome 0x04000000 (0x06000000 for stores).
  - External-control class 3 raises a data fault with syndrome 0x04100000 (0x06100000 for stores).
  - Floating-point class 1 raises an alignment fault (kind 3).
  - Cache-operation class 4 completes with no fault, real address = effective address and permission 3'b000.
- R7: A fetch through a non-direct-store segment whose no-execute bit 28 is set raises an instruction fault with code 0x10000000.
- R8: A page-table miss (`pt_found`=0) raises, for a fetch, an instruction fault with code 0x40000000. For a load or store it raises a data fault with syndrome 0x40000000, or 0x42000000 for stores.
- R9: A page-table hit decodes the 2-bit page protection `pt_pp` into read/write permission.
  - With key 0: values 0, 1 and 2 give R+W, and value 3 gives R.
  - With key 1: value 0 gives nothing, 1 gives R, 2 gives R+W and 3 gives R.
  - X is added when R is granted and segment bit 28 is 0.
  - A missing permission faults with code/syndrome 0x08000000 (0x0A000000 for stores).
  - Otherwise the real address is {pt_rpn, ea[11:0]}.
- R10: The protection key is segment bit 29 for user accesses (`req_user`=1) and segment bit 30 for privileged ones.
- R11: Fault outputs follow these rules.
  - The fault address output is loaded with the effective address on every data or alignment fault, and holds its value on any other result.
  - The error code output is nonzero only for instruction faults.
  - The syndrome output is nonzero only for data faults.
  - Every fault reports real address 0 and permission 0.
- R12: `rsp_done` pulses for one cycle exactly one clock after each request. All result outputs stay unchanged until the next request. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle translation request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_class | input | 3 | Data class: 0 integer, 1 float, 2 reservation, 3 external, 4 cache op |
| req_real | input | 1 | Translation disabled |
| req_user | input | 1 | Unprivileged access |
| bt_hit | input | 1 | Block-translation match |
| bt_raddr | input | 32 | Real address from block translation |
| bt_perm | input | 3 | Block permission {X,W,R} |
| seg_file | input | 512 | Sixteen 32-bit segment registers |
| pt_found | input | 1 | Page-table search found an entry |
| pt_rpn | input | 20 | Real page number of that entry |
| pt_pp | input | 2 | Page protection field of that entry |
| rsp_done | output | 1 | Result valid pulse |
| rsp_raddr | output | 32 | Real address |
| rsp_perm | output | 3 | Permitted access set {X,W,R} |
| rsp_exc | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| rsp_code | output | 32 | Instruction fault error code |
| rsp_syn | output | 32 | Data fault syndrome |
| rsp_far | output | 32 | Fault address |

## Verification
Three situations can arrive together in one request:
- a block-translation hit, together with a segment that would itself fault or bypass (direct-store, no-execute, or page-table miss);
- real mode, together with all of the above.

The sweep provokes these collisions by crossing every block-translation state with every segment kind, page state and real-mode value. It judges each result against the stated priority: real mode first, then the block, then the segment. The other segment slots hold a bypass pattern with a distinct nibble, so a wrong slot choice shows up in the real address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int XW = 32;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_FLOAT = 3'd1,
    CLS_RESV  = 3'd2,
    CLS_EXT   = 3'd3,
    CLS_CACHE = 3'd4
  } acc_class_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_INSN  = 2'd1,
    EXC_DATA  = 2'd2,
    EXC_ALIGN = 2'd3
  } exc_kind_e;

  localparam logic [XW-1:0] SYN_STORE    = 32'h0200_0000;
  localparam logic [XW-1:0] CODE_PROT    = 32'h0800_0000;
  localparam logic [XW-1:0] CODE_NOEXEC  = 32'h1000_0000;
  localparam logic [XW-1:0] CODE_MISS    = 32'h4000_0000;
  localparam logic [XW-1:0] SYN_RESV     = 32'h0400_0000;
  localparam logic [XW-1:0] SYN_EXT      = 32'h0410_0000;
  localparam logic [8:0]    BUID_BYPASS  = 9'h07F;

  localparam int SEG_DS_BIT = 31;
  localparam int SEG_KS_BIT = 30;
  localparam int SEG_KU_BIT = 29;
  localparam int SEG_NX_BIT = 28;

  typedef struct packed {
    logic [XW-1:0] raddr;
    logic [2:0]    perm;
    exc_kind_e     exc;
    logic [XW-1:0] code;
    logic [XW-1:0] syn;
    logic          far_load;
  } xlate_res_t;
endpackage

// File: rtl/xlate_seg_sel.sv
module xlate_seg_sel #(
  parameter int NSEG  = 16,
  parameter int SEL_W = $clog2(NSEG)
) (
  input  logic [NSEG*32-1:0] seg_file,
  input  logic [SEL_W-1:0]   sel,
  output logic [31:0]        seg
);
  logic [31:0] slots [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    assign slots[g] = seg_file[g*32 +: 32];
  end

  assign seg = slots[sel];
endmodule

// File: rtl/xlate_prot.sv
module xlate_prot (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       nx,
  output logic [2:0] perm
);
  logic rd, wr;

  always_comb begin
    rd = 1'b1;
    wr = 1'b0;
    if (!key) begin
      wr = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0:    rd = 1'b0;
        2'd2:    wr = 1'b1;
        default: wr = 1'b0;
      endcase
    end
    perm = {rd & ~nx, wr, rd};
  end
endmodule

// File: rtl/xlate_decide.sv
module xlate_decide
  import xlate_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  localparam int RPN_W    = XW - PAGE_BITS
) (
  input  logic          real_mode,
  input  acc_kind_e     kind,
  input  acc_class_e    cls,
  input  logic [XW-1:0] ea,
  input  logic          bt_hit,
  input  logic [XW-1:0] bt_raddr,
  input  logic [2:0]    bt_perm,
  input  logic [31:0]   seg,
  input  logic          key,
  input  logic          pt_found,
  input  logic [RPN_W-1:0] pt_rpn,
  input  logic [2:0]    pt_perm,
  output xlate_res_t    res
);
  logic [2:0] need;
  logic       is_fetch, is_store;
  logic [2:0] ds_perm;

  function automatic xlate_res_t insn_fault(input logic [XW-1:0] c);
    xlate_res_t r;
    r = '0;
    r.exc  = EXC_INSN;
    r.code = c;
    return r;
  endfunction

  function automatic xlate_res_t data_fault(input logic [XW-1:0] base, input logic st);
    xlate_res_t r;
    r = '0;
    r.exc      = EXC_DATA;
    r.syn      = base | (st ? SYN_STORE : '0);
    r.far_load = 1'b1;
    return r;
  endfunction

  function automatic xlate_res_t perm_fault(input logic f, input logic st);
    return f ? insn_fault(CODE_PROT) : data_fault(CODE_PROT, st);
  endfunction

  function automatic xlate_res_t grant(input logic [XW-1:0] a, input logic [2:0] p);
    xlate_res_t r;
    r = '0;
    r.raddr = a;
    r.perm  = p;
    return r;
  endfunction

  assign is_fetch = (kind == ACC_FETCH);
  assign is_store = (kind == ACC_STORE);
  assign ds_perm  = key ? 3'b011 : 3'b001;

  always_comb begin
    unique case (kind)
      ACC_FETCH: need = 3'b100;
      ACC_STORE: need = 3'b010;
      default:   need = 3'b001;
    endcase
  end

  always_comb begin
    res = '0;
    if (real_mode) begin
      res = grant(ea, 3'b111);
    end else if (bt_hit) begin
      if ((need & ~bt_perm) != 3'b000) res = perm_fault(is_fetch, is_store);
      else                             res = grant(bt_raddr, bt_perm);
    end else if (seg[SEG_DS_BIT]) begin
      if (seg[28:20] == BUID_BYPASS) begin
        res = grant({seg[3:0], ea[27:0]}, 3'b111);
      end else if (is_fetch) begin
        res = insn_fault(CODE_NOEXEC);
      end else begin
        unique case (cls)
          CLS_INT: begin
            if ((need & ~ds_perm) != 3'b000) res = data_fault(CODE_PROT, is_store);
            else                             res = grant(ea, ds_perm);
          end
          CLS_FLOAT: begin
            res = '0;
            res.exc      = EXC_ALIGN;
            res.far_load = 1'b1;
          end
          CLS_RESV:  res = data_fault(SYN_RESV, is_store);
          CLS_EXT:   res = data_fault(SYN_EXT, is_store);
          default:   res = grant(ea, 3'b000);
        endcase
      end
    end else if (is_fetch && seg[SEG_NX_BIT]) begin
      res = insn_fault(CODE_NOEXEC);
    end else if (!pt_found) begin
      res = is_fetch ? insn_fault(CODE_MISS) : data_fault(CODE_MISS, is_store);
    end else if ((need & ~pt_perm) != 3'b000) begin
      res = perm_fault(is_fetch, is_store);
    end else begin
      res = grant({pt_rpn, ea[PAGE_BITS-1:0]}, pt_perm);
    end
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
#(
  parameter int NSEG      = 16,
  parameter int PAGE_BITS = 12,
  localparam int SEL_W    = $clog2(NSEG),
  localparam int RPN_W    = XW - PAGE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [XW-1:0]       req_ea,
  input  logic [1:0]          req_kind,
  input  logic [2:0]          req_class,
  input  logic                req_real,
  input  logic                req_user,
  input  logic                bt_hit,
  input  logic [XW-1:0]       bt_raddr,
  input  logic [2:0]          bt_perm,
  input  logic [NSEG*32-1:0]  seg_file,
  input  logic                pt_found,
  input  logic [RPN_W-1:0]    pt_rpn,
  input  logic [1:0]          pt_pp,
  output logic                rsp_done,
  output logic [XW-1:0]       rsp_raddr,
  output logic [2:0]          rsp_perm,
  output logic [1:0]          rsp_exc,
  output logic [XW-1:0]       rsp_code,
  output logic [XW-1:0]       rsp_syn,
  output logic [XW-1:0]       rsp_far
);
  logic [31:0] seg;
  logic        key;
  logic [2:0]  pt_perm;
  xlate_res_t  res;

  logic          done_q, done_d;
  logic [XW-1:0] raddr_q, code_q, syn_q, far_q, far_d;
  logic [2:0]    perm_q;
  logic [1:0]    exc_q;
  logic          res_en;

  xlate_seg_sel #(.NSEG(NSEG)) u_seg_sel (
    .seg_file (seg_file),
    .sel      (req_ea[XW-1 -: SEL_W]),
    .seg      (seg)
  );

  assign key = req_user ? seg[SEG_KU_BIT] : seg[SEG_KS_BIT];

  xlate_prot u_prot (
    .key  (key),
    .pp   (pt_pp),
    .nx   (seg[SEG_NX_BIT]),
    .perm (pt_perm)
  );

  xlate_decide #(.PAGE_BITS(PAGE_BITS)) u_decide (
    .real_mode (req_real),
    .kind      (acc_kind_e'(req_kind)),
    .cls       (acc_class_e'(req_class)),
    .ea        (req_ea),
    .bt_hit    (bt_hit),
    .bt_raddr  (bt_raddr),
    .bt_perm   (bt_perm),
    .seg       (seg),
    .key       (key),
    .pt_found  (pt_found),
    .pt_rpn    (pt_rpn),
    .pt_perm   (pt_perm),
    .res       (res)
  );

  // next state
  always_comb begin
    done_d = req_valid;
    res_en = req_valid;
    far_d  = (req_valid && res.far_load) ? req_ea : far_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      raddr_q <= '0;
      perm_q  <= '0;
      exc_q   <= '0;
      code_q  <= '0;
      syn_q   <= '0;
      far_q   <= '0;
    end else begin
      done_q <= done_d;
      far_q  <= far_d;
      if (res_en) begin
        raddr_q <= res.raddr;
        perm_q  <= res.perm;
        exc_q   <= res.exc;
        code_q  <= res.code;
        syn_q   <= res.syn;
      end
    end
  end

  assign rsp_done  = done_q;
  assign rsp_raddr = raddr_q;
  assign rsp_perm  = perm_q;
  assign rsp_exc   = exc_q;
  assign rsp_code  = code_q;
  assign rsp_syn   = syn_q;
  assign rsp_far   = far_q;
endmodule

// File: rtl/xlate_seq_chk.sv
module xlate_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        req_real,
  input logic        rsp_done,
  input logic [31:0] rsp_raddr,
  input logic [2:0]  rsp_perm,
  input logic [1:0]  rsp_exc,
  input logic [31:0] rsp_code,
  input logic [31:0] rsp_syn,
  input logic [31:0] rsp_far
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done); // R12
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(req_valid)); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_raddr) && $stable(rsp_exc) && $stable(rsp_far))); // R12
  AST_REAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_real) |=> (rsp_raddr == $past(req_ea) && rsp_perm == 3'b111 && rsp_exc == 2'd0)); // R1
  AST_FAR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_exc == 2'd2) |-> (rsp_far == $past(req_ea))); // R11
  AST_INSN_NO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_exc == 2'd1) |-> (rsp_syn == 32'h0 && rsp_code != 32'h0)); // R11
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_exc != 2'd0) |-> (rsp_perm == 3'b000 && rsp_raddr == 32'h0)); // R11
endmodule

bind xlate_seq xlate_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ea    (req_ea),
  .req_real  (req_real),
  .rsp_done  (rsp_done),
  .rsp_raddr (rsp_raddr),
  .rsp_perm  (rsp_perm),
  .rsp_exc   (rsp_exc),
  .rsp_code  (rsp_code),
  .rsp_syn   (rsp_syn),
  .rsp_far   (rsp_far)
);

// File: tb/xlate_seq_bench.sv
`timescale 1ns/1ps
module xlate_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_ea;
  logic [1:0]   req_kind;
  logic [2:0]   req_class;
  logic         req_real, req_user;
  logic         bt_hit;
  logic [31:0]  bt_raddr;
  logic [2:0]   bt_perm;
  logic [511:0] seg_file;
  logic         pt_found;
  logic [19:0]  pt_rpn;
  logic [1:0]   pt_pp;
  logic         rsp_done;
  logic [31:0]  rsp_raddr, rsp_code, rsp_syn, rsp_far;
  logic [2:0]   rsp_perm;
  logic [1:0]   rsp_exc;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1357_9BDF;

  logic [31:0] e_raddr, e_code, e_syn, e_far;
  logic [2:0]  e_perm;
  logic [1:0]  e_exc;
  string       e_tag;

  always #2.5 clk = ~clk;

  xlate_seq u_xlate_seq (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic set_fault(input logic [1:0] k, input logic [31:0] c, input logic [31:0] s, input logic ld);
    e_raddr = 0; e_perm = 0; e_exc = k; e_code = c; e_syn = s;
    if (ld) e_far = req_ea;
  endtask

  task automatic model(input logic [31:0] seg);
    logic [2:0] need, p;
    logic key, st, fe, rd, wr;
    fe = (req_kind == 0);
    st = (req_kind == 2);
    need = fe ? 3'b100 : (st ? 3'b010 : 3'b001);
    key = req_user ? seg[29] : seg[30]; // R10
    if (req_real) begin
      e_tag = "R1"; e_raddr = req_ea; e_perm = 7; e_exc = 0; e_code = 0; e_syn = 0;
    end else if (bt_hit) begin
      e_tag = "R2";
      if ((need & ~bt_perm) != 0) begin
        if (fe) set_fault(1, 32'h0800_0000, 0, 0);
        else    set_fault(2, 0, st ? 32'h0A00_0000 : 32'h0800_0000, 1);
      end else begin
        e_raddr = bt_raddr; e_perm = bt_perm; e_exc = 0; e_code = 0; e_syn = 0;
      end
    end else if (seg[31] && seg[28:20] == 9'h07F) begin
      e_tag = "R4"; e_raddr = {seg[3:0], req_ea[27:0]}; e_perm = 7; e_exc = 0; e_code = 0; e_syn = 0;
    end else if (seg[31]) begin
      e_tag = (req_class == 0 || fe) ? "R5" : "R6";
      if (fe) set_fault(1, 32'h1000_0000, 0, 0);
      else case (req_class)
        3'd0: begin
          p = key ? 3'b011 : 3'b001;
          if ((need & ~p) != 0) set_fault(2, 0, st ? 32'h0A00_0000 : 32'h0800_0000, 1);
          else begin e_raddr = req_ea; e_perm = p; e_exc = 0; e_code = 0; e_syn = 0; end
        end
        3'd1: set_fault(3, 0, 0, 1);
        3'd2: set_fault(2, 0, st ? 32'h0600_0000 : 32'h0400_0000, 1);
        3'd3: set_fault(2, 0, st ? 32'h0610_0000 : 32'h0410_0000, 1);
        default: begin e_raddr = req_ea; e_perm = 0; e_exc = 0; e_code = 0; e_syn = 0; end
      endcase
    end else if (fe && seg[28]) begin
      e_tag = "R7"; set_fault(1, 32'h1000_0000, 0, 0);
    end else if (!pt_found) begin
      e_tag = "R8";
      if (fe) set_fault(1, 32'h4000_0000, 0, 0);
      else    set_fault(2, 0, st ? 32'h4200_0000 : 32'h4000_0000, 1);
    end else begin
      e_tag = "R9";
      rd = !(key && pt_pp == 0);
      wr = key ? (pt_pp == 2) : (pt_pp != 3);
      p = {rd & ~seg[28], wr, rd};
      if ((need & ~p) != 0) begin
        if (fe) set_fault(1, 32'h0800_0000, 0, 0);
        else    set_fault(2, 0, st ? 32'h0A00_0000 : 32'h0800_0000, 1);
      end else begin
        e_raddr = {pt_rpn, req_ea[11:0]}; e_perm = p; e_exc = 0; e_code = 0; e_syn = 0;
      end
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seg_t, poison, prev_raddr;
    logic [3:0]  nib;
    logic [2:0]  btp [5];
    btp[0] = 0; btp[1] = 3'b111; btp[2] = 3'b001; btp[3] = 3'b011; btp[4] = 3'b000;
    rst_n = 0; req_valid = 0; req_ea = 0; req_kind = 0; req_class = 0; req_real = 0;
    req_user = 0; bt_hit = 0; bt_raddr = 0; bt_perm = 0; seg_file = '0;
    pt_found = 0; pt_rpn = 0; pt_pp = 0;
    e_far = 0; nib = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "reset done", {31'b0, rsp_done}, 0);
    chk("R12", "reset raddr", rsp_raddr, 0);
    chk("R12", "reset far", rsp_far, 0);
    chk("R12", "reset exc", {30'b0, rsp_exc}, 0);
    poison = {1'b1, 2'b00, 9'h07F, 16'h0, 4'h5};
    for (int k = 0; k < 3; k++)
     for (int c = 0; c < 5; c++)
      for (int u = 0; u < 2; u++)
       for (int rm = 0; rm < 2; rm++)
        for (int b = 0; b < 5; b++)
         for (int sk = 0; sk < 4; sk++)
          for (int ky = 0; ky < 4; ky++)
           for (int pf = 0; pf < 2; pf++)
            for (int pp = 0; pp < 4; pp++) begin
              lfsr = step(lfsr);
              nib = nib + 4'd1;
              unique case (sk)
                0: seg_t = {1'b0, ky[1], ky[0], 1'b0, 4'h0, lfsr[23:0]};
                1: seg_t = {1'b0, ky[1], ky[0], 1'b1, 4'h0, lfsr[23:0]};
                2: seg_t = {1'b1, ky[1], ky[0], 9'h07F, 16'h0, 4'hC};
                default: seg_t = {1'b1, ky[1], ky[0], 9'h012, 16'h0, 4'h3};
              endcase
              for (int s = 0; s < 16; s++) seg_file[s*32 +: 32] = (s == int'(nib)) ? seg_t : poison;
              req_ea = {nib, lfsr[27:0]};
              req_kind = k[1:0]; req_class = c[2:0]; req_user = u[0]; req_real = rm[0];
              bt_hit = (b != 0); bt_perm = btp[b]; bt_raddr = step(lfsr) ^ 32'hA5A5_0000;
              pt_found = pf[0]; pt_pp = pp[1:0]; pt_rpn = lfsr[31:12] ^ 20'h5A5A5;
              model(seg_t);
              req_valid = 1;
              @(negedge clk);
              req_valid = 0;
              // R3: wrong slot would produce the poison bypass address
              chk(e_tag, "done", {31'b0, rsp_done}, 1);
              chk(e_tag, "raddr R3", rsp_raddr, e_raddr);
              chk(e_tag, "perm", {29'b0, rsp_perm}, {29'b0, e_perm});
              chk(e_tag, "exc", {30'b0, rsp_exc}, {30'b0, e_exc});
              chk(e_tag, "code R11", rsp_code, e_code);
              chk(e_tag, "syn R11", rsp_syn, e_syn);
              chk("R11", "far", rsp_far, e_far);
              prev_raddr = rsp_raddr;
              req_ea = ~req_ea; bt_hit = ~bt_hit;
              @(negedge clk);
              chk("R12", "done drop", {31'b0, rsp_done}, 0);
              chk("R12", "hold raddr", rsp_raddr, prev_raddr);
              chk("R12", "hold far", rsp_far, e_far);
            end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule